// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit turns a fast input clock into the time-quantum tick of a CAN controller and lays out every nominal bit as a run of quanta. The tick comes from three cascaded stages:
- a power-of-two divider, picked by a select field;
- a fixed halving stage;
- a baud-rate prescaler that divides by the programmed value plus one.

Each bit runs through four segments in a fixed order: a one-quantum sync slot, a propagation slot, a first phase slot and a second phase slot. The unit raises a strobe at the sample point, which sits between the two phase slots. It raises a second strobe when the bit closes.

The receive line is captured once per quantum. A high-to-low step between two captures counts as a synchronizing edge. While the bus is idle, such an edge forces a hard synchronization. Otherwise the edge drives a resynchronization, limited by the jump width: a late edge stretches the first phase slot, and an early edge trims the second. The surrounding controller supplies the segment lengths and two qualifiers: bus idle, and transmitting dominant. It consumes the strobes and the sampled bit.

Top module: `can_bit_timer`

## Requirements
- R1: `tqTick` is a one-clock pulse with period 2^s·2·(brp+1) clocks. Here s = `clkSel` for codes 0..4, and any larger code acts as 4. The first pulse falls in the cycle that follows the (period−1)-th rising edge after reset release.
- R2: In reset, `segment` is 0, `samplePulse` and `bitEndPulse` are low, and `sampledBit` is 1.
- R3: `segment` codes are 0 = sync (1 Tq), 1 = propagation (`propCfg`+1 Tq), 2 = phase one (`ph1Cfg`+1 Tq plus any extension) and 3 = phase two (`ph2Cfg`+1 Tq minus any trim). The code changes only in the clock after a tick.
- R4: `samplePulse` is high for the one clock after the tick that closes phase one. In that same clock, `sampledBit` takes the receive level captured at the tick before.
- R5: `bitEndPulse` is high for the one clock after the tick that closes phase two.
- R6: `rxIn` passes through two stages that load only on a tick. An edge is a 1 in the older stage with a 0 in the newer one. Low-to-high steps never cause synchronization.
- R7: An edge while `busIdle` is 1 makes the next quantum the first propagation quantum. No strobe is raised for it, and a further resynchronization in that bit is blocked.
- R8: An edge in quantum k of the bit, where 1 ≤ k ≤ end of phase one, lengthens phase one by min(k, `sjwCfg`+1).
- R9: An edge in phase two, with r quanta left after its quantum, shortens phase two by min(r, `sjwCfg`+1). When r ≤ `sjwCfg`+1, the bit closes at that tick.
- R10: An edge in the sync quantum changes no length.
- R11: At most one resynchronization takes effect per bit. The counter is cleared when the bit closes.
- R12: While `txDominant` is 1, an edge in phase two has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | First-stage divide select, 2^clkSel, saturating at 16 |
| brp | input | 4 | Baud-rate prescaler value, divide by brp+1 |
| propCfg | input | 3 | Propagation length minus one |
| ph1Cfg | input | 3 | Phase-one length minus one |
| ph2Cfg | input | 3 | Phase-two length minus one |
| sjwCfg | input | 2 | Jump width minus one |
| busIdle | input | 1 | Bus idle qualifier, selects hard synchronization |
| txDominant | input | 1 | Node is transmitting a dominant level |
| rxIn | input | 1 | Receive line, 1 = recessive |
| tqTick | output | 1 | Time-quantum tick |
| segment | output | 2 | Current segment code |
| samplePulse | output | 1 | Sample-point strobe |
| bitEndPulse | output | 1 | Bit-boundary strobe |
| sampledBit | output | 1 | Receive level taken at the last sample point |

## Verification
The bench drives receive waveforms whose period drifts against the bit length. This places edges in every segment: edges late enough to stretch phase one by more than the jump width, and edges early enough to close the bit on the spot. A design that measures the phase error from the wrong origin, or that ignores the jump-width cap, shows up as segment codes and strobes that are one or more quanta off. Random glitch trains then put several edges into one bit and edges into the sync quantum. These catch a design that resynchronizes twice per bit or adjusts on a zero error. The transmit-dominant and idle-bus runs catch a design that trims phase two while transmitting dominant, or that hard-synchronizes to the wrong quantum. Separate runs cover a divider select above the legal range and a non-zero prescaler, which expose a mis-chained tick.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  // Strobes from the control FSM to the datapath, all valid on a tick only.
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic loadExt;
    logic loadCut;
    logic clearAdj;
    logic takeSample;
  } dp_cmd_t;

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int SEL_W      = 3,
  parameter int DIV_STAGES = 5,
  parameter int BRP_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [BRP_W-1:0] brp,
  output logic             tqTick
);

  localparam int DIV_W = DIV_STAGES - 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(DIV_STAGES - 1);

  logic [DIV_W-1:0] lastTable [DIV_STAGES];
  logic [DIV_W-1:0] stage1Cnt;
  logic [SEL_W-1:0] selEff;
  logic             sysEn;
  logic             halfPh;
  logic             canEn;
  logic [BRP_W-1:0] brpCnt;

  // Terminal count of the first stage for every legal select code.
  for (genvar g = 0; g < DIV_STAGES; g++) begin : g_last
    assign lastTable[g] = DIV_W'((1 << g) - 1);
  end

  assign selEff = (clkSel > SEL_MAX) ? SEL_MAX : clkSel;
  assign sysEn  = (stage1Cnt == lastTable[selEff]);
  assign canEn  = sysEn & halfPh;
  assign tqTick = canEn & (brpCnt == brp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Cnt <= '0;
    end else if (sysEn) begin
      stage1Cnt <= '0;
    end else begin
      stage1Cnt <= stage1Cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfPh <= 1'b0;
    end else if (sysEn) begin
      halfPh <= ~halfPh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brpCnt <= '0;
    end else if (canEn) begin
      if (brpCnt == brp) begin
        brpCnt <= '0;
      end else begin
        brpCnt <= brpCnt + BRP_W'(1);
      end
    end
  end

endmodule

// File: rtl/can_bt_datapath.sv
module can_bt_datapath
  import can_bt_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int DIV_STAGES = 5,
  parameter int BRP_W      = 4,
  parameter int RX_STAGES  = 2,
  parameter int CNT_W      = 4,
  parameter int ADJ_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [BRP_W-1:0] brp,
  input  logic             rxIn,
  input  dp_cmd_t          cmd,
  input  logic [ADJ_W-1:0] adjVal,
  output logic             tqTick,
  output logic             fallEdge,
  output logic             rxLevel,
  output logic [CNT_W-1:0] quantCnt,
  output logic [ADJ_W-1:0] ph1Ext,
  output logic [ADJ_W-1:0] ph2Cut,
  output logic             sampledBit
);

  logic [RX_STAGES-1:0] rxPipe;

  can_bt_prescaler #(
    .SEL_W     (SEL_W),
    .DIV_STAGES(DIV_STAGES),
    .BRP_W     (BRP_W)
  ) i_prescaler (
    .clk   (clk),
    .rstN  (rstN),
    .clkSel(clkSel),
    .brp   (brp),
    .tqTick(tqTick)
  );

  // Receive capture: loads once per quantum, idles recessive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPipe <= '1;
    end else if (tqTick) begin
      rxPipe <= {rxPipe[RX_STAGES-2:0], rxIn};
    end
  end

  assign rxLevel  = rxPipe[RX_STAGES-2];
  assign fallEdge = tqTick & rxPipe[RX_STAGES-1] & ~rxPipe[RX_STAGES-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quantCnt <= '0;
    end else if (cmd.cntClear) begin
      quantCnt <= '0;
    end else if (cmd.cntStep) begin
      quantCnt <= quantCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph1Ext <= '0;
      ph2Cut <= '0;
    end else if (cmd.clearAdj) begin
      ph1Ext <= '0;
      ph2Cut <= '0;
    end else begin
      if (cmd.loadExt) begin
        ph1Ext <= adjVal;
      end
      if (cmd.loadCut) begin
        ph2Cut <= adjVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampledBit <= 1'b1;
    end else if (cmd.takeSample) begin
      sampledBit <= rxLevel;
    end
  end

endmodule

// File: rtl/can_bt_ctrl.sv
module can_bt_ctrl
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2,
  parameter int CNT_W = 4,
  parameter int ADJ_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             fallEdge,
  input  logic             busIdle,
  input  logic             txDominant,
  input  logic [CNT_W-1:0] quantCnt,
  input  logic [ADJ_W-1:0] ph1Ext,
  input  logic [ADJ_W-1:0] ph2Cut,
  input  logic [SEG_W-1:0] propCfg,
  input  logic [SEG_W-1:0] ph1Cfg,
  input  logic [SEG_W-1:0] ph2Cfg,
  input  logic [SJW_W-1:0] sjwCfg,
  output dp_cmd_t          cmd,
  output logic [ADJ_W-1:0] adjVal,
  output logic [1:0]       segment,
  output logic             samplePulse,
  output logic             bitEndPulse
);

  localparam int ERR_W = CNT_W + 2;
  localparam logic [ERR_W-1:0] ONE = ERR_W'(1);

  seg_e             segQ;
  seg_e             segNext;
  logic             resyncUsed;
  logic [ERR_W-1:0] propLen, ph1Len, ph2Len, sjwLen, cntE;
  logic [ERR_W-1:0] lateErr, earlyErr, phaseErr, adjWide, ph1Eff, ph2Eff;
  logic             doHard, resyncOk, doLate, doEarly, segDone, bitDone, sampleNow;

  always_comb begin
    propLen  = ERR_W'(propCfg) + ONE;
    ph1Len   = ERR_W'(ph1Cfg) + ONE;
    ph2Len   = ERR_W'(ph2Cfg) + ONE;
    sjwLen   = ERR_W'(sjwCfg) + ONE;
    cntE     = ERR_W'(quantCnt);
    // Late error: quanta from the end of sync up to the edge quantum.
    lateErr  = (segQ == SEG_PROP) ? (cntE + ONE) : (propLen + cntE + ONE);
    // Early error: quanta still left in phase two after the edge quantum.
    earlyErr = ph2Len - cntE - ONE;
    phaseErr = (segQ == SEG_PH2) ? earlyErr : lateErr;
    adjWide  = (phaseErr < sjwLen) ? phaseErr : sjwLen;
  end

  assign doHard   = tick & fallEdge & busIdle;
  assign resyncOk = tick & fallEdge & ~busIdle & ~resyncUsed;
  assign doLate   = resyncOk & ((segQ == SEG_PROP) | (segQ == SEG_PH1));
  assign doEarly  = resyncOk & (segQ == SEG_PH2) & ~txDominant;
  assign adjVal   = adjWide[ADJ_W-1:0];

  assign ph1Eff = ph1Len + (doLate ? adjWide : ERR_W'(ph1Ext));
  assign ph2Eff = ph2Len - (doEarly ? adjWide : ERR_W'(ph2Cut));

  always_comb begin
    unique case (segQ)
      SEG_SYNC: segDone = 1'b1;
      SEG_PROP: segDone = (cntE == propLen - ONE);
      SEG_PH1:  segDone = (cntE == ph1Eff - ONE);
      default:  segDone = (cntE == ph2Eff - ONE);
    endcase
  end

  assign bitDone   = tick & ~doHard & segDone & (segQ == SEG_PH2);
  assign sampleNow = tick & ~doHard & segDone & (segQ == SEG_PH1);

  always_comb begin
    cmd            = '0;
    cmd.cntClear   = tick & (doHard | segDone);
    cmd.cntStep    = tick & ~doHard & ~segDone;
    cmd.loadExt    = doLate;
    cmd.loadCut    = doEarly;
    cmd.clearAdj   = doHard | bitDone;
    cmd.takeSample = sampleNow;
  end

  always_comb begin
    segNext = segQ;
    if (doHard) begin
      segNext = SEG_PROP;
    end else if (tick && segDone) begin
      unique case (segQ)
        SEG_SYNC: segNext = SEG_PROP;
        SEG_PROP: segNext = SEG_PH1;
        SEG_PH1:  segNext = SEG_PH2;
        default:  segNext = SEG_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segQ        <= SEG_SYNC;
      resyncUsed  <= 1'b0;
      samplePulse <= 1'b0;
      bitEndPulse <= 1'b0;
    end else begin
      segQ        <= segNext;
      samplePulse <= sampleNow;
      bitEndPulse <= bitDone;
      if (doHard) begin
        resyncUsed <= 1'b1;
      end else if (bitDone) begin
        resyncUsed <= 1'b0;
      end else if (doLate || doEarly) begin
        resyncUsed <= 1'b1;
      end
    end
  end

  assign segment = segQ;

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int DIV_STAGES = 5,
  parameter int BRP_W      = 4,
  parameter int SEG_W      = 3,
  parameter int SJW_W      = 2,
  parameter int RX_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [BRP_W-1:0] brp,
  input  logic [SEG_W-1:0] propCfg,
  input  logic [SEG_W-1:0] ph1Cfg,
  input  logic [SEG_W-1:0] ph2Cfg,
  input  logic [SJW_W-1:0] sjwCfg,
  input  logic             busIdle,
  input  logic             txDominant,
  input  logic             rxIn,
  output logic             tqTick,
  output logic [1:0]       segment,
  output logic             samplePulse,
  output logic             bitEndPulse,
  output logic             sampledBit
);

  localparam int ADJ_W = SJW_W + 1;
  localparam int CNT_W = ((SEG_W > SJW_W) ? SEG_W : SJW_W) + 1;

  dp_cmd_t          cmd;
  logic [ADJ_W-1:0] adjVal;
  logic             fallEdge;
  logic             rxLevel;
  logic [CNT_W-1:0] quantCnt;
  logic [ADJ_W-1:0] ph1Ext;
  logic [ADJ_W-1:0] ph2Cut;

  can_bt_datapath #(
    .SEL_W     (SEL_W),
    .DIV_STAGES(DIV_STAGES),
    .BRP_W     (BRP_W),
    .RX_STAGES (RX_STAGES),
    .CNT_W     (CNT_W),
    .ADJ_W     (ADJ_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .clkSel    (clkSel),
    .brp       (brp),
    .rxIn      (rxIn),
    .cmd       (cmd),
    .adjVal    (adjVal),
    .tqTick    (tqTick),
    .fallEdge  (fallEdge),
    .rxLevel   (rxLevel),
    .quantCnt  (quantCnt),
    .ph1Ext    (ph1Ext),
    .ph2Cut    (ph2Cut),
    .sampledBit(sampledBit)
  );

  can_bt_ctrl #(
    .SEG_W(SEG_W),
    .SJW_W(SJW_W),
    .CNT_W(CNT_W),
    .ADJ_W(ADJ_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tqTick),
    .fallEdge   (fallEdge),
    .busIdle    (busIdle),
    .txDominant (txDominant),
    .quantCnt   (quantCnt),
    .ph1Ext     (ph1Ext),
    .ph2Cut     (ph2Cut),
    .propCfg    (propCfg),
    .ph1Cfg     (ph1Cfg),
    .ph2Cfg     (ph2Cfg),
    .sjwCfg     (sjwCfg),
    .cmd        (cmd),
    .adjVal     (adjVal),
    .segment    (segment),
    .samplePulse(samplePulse),
    .bitEndPulse(bitEndPulse)
  );

  // rxLevel feeds only the datapath's own sample register.
  logic unusedLevel;
  assign unusedLevel = rxLevel;

endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tqTick,
  input logic       samplePulse,
  input logic       bitEndPulse,
  input logic [1:0] segment
);

  // R1: the tick never lasts two clocks (shortest period is two clocks).
  a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rstN)
    tqTick |=> !tqTick);

  // R3: the segment code moves only after a tick.
  a_r3_seg_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    (segment != $past(segment)) |-> $past(tqTick));

  // R3/R7: segments advance in order, or jump to propagation.
  a_r3_seg_order: assert property (@(posedge clk) disable iff (!rstN)
    (segment != $past(segment)) |->
      ((segment == $past(segment) + 2'd1) || (segment == 2'd1)));

  // R4: the sample strobe marks the step from phase one to phase two.
  a_r4_sample_on_ph1_exit: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> (($past(segment) == 2'd2) && (segment == 2'd3)));

  // R5: the bit strobe marks leaving phase two into sync.
  a_r5_bitend_on_ph2_exit: assert property (@(posedge clk) disable iff (!rstN)
    bitEndPulse |-> (($past(segment) == 2'd3) && (segment == 2'd0)));

  // R5: the two strobes never coincide.
  a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(samplePulse && bitEndPulse));

endmodule

bind can_bit_timer can_bt_checker i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .tqTick     (tqTick),
  .samplePulse(samplePulse),
  .bitEndPulse(bitEndPulse),
  .segment    (segment)
);

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] clkSel = '0;
  logic [3:0] brp = '0;
  logic [2:0] propCfg = '0;
  logic [2:0] ph1Cfg = 3'd1;
  logic [2:0] ph2Cfg = 3'd1;
  logic [1:0] sjwCfg = '0;
  logic       busIdle = 1'b0;
  logic       txDominant = 1'b0;
  logic       rxIn = 1'b1;
  logic       tqTick;
  logic [1:0] segment;
  logic       samplePulse;
  logic       bitEndPulse;
  logic       sampledBit;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #2.5 clk = ~clk;

  can_bit_timer i_can_bit_timer (
    .clk        (clk),
    .rstN       (rstN),
    .clkSel     (clkSel),
    .brp        (brp),
    .propCfg    (propCfg),
    .ph1Cfg     (ph1Cfg),
    .ph2Cfg     (ph2Cfg),
    .sjwCfg     (sjwCfg),
    .busIdle    (busIdle),
    .txDominant (txDominant),
    .rxIn       (rxIn),
    .tqTick     (tqTick),
    .segment    (segment),
    .samplePulse(samplePulse),
    .bitEndPulse(bitEndPulse),
    .sampledBit (sampledBit)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s: %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Behavioural reference: position within the bit counted in quanta.
  task automatic runScn(input int sel, input int bv, input int pc, input int a1, input int a2,
                        input int sj, input int idleTicks, input int mode, input int halfPer,
                        input int txd, input int numQ, input string tag);
    int P, A, B, S, T, divN, k, tickN;
    int pos, ext, cut, used, ms1, ms2;
    int expSeg, expSample, expEnd, expBit;
    int lfsr;
    P = pc + 1; A = a1 + 1; B = a2 + 1; S = sj + 1;
    divN = 1 << ((sel > 4) ? 4 : sel);
    T = divN * 2 * (bv + 1);
    pos = 0; ext = 0; cut = 0; used = 0; ms1 = 1; ms2 = 1;
    expSeg = 0; expSample = 0; expEnd = 0; expBit = 1;
    lfsr = 16'hACE1; tickN = 0; k = 0;

    @(negedge clk);
    rstN = 1'b0;
    clkSel = 3'(sel); brp = 4'(bv); propCfg = 3'(pc); ph1Cfg = 3'(a1); ph2Cfg = 3'(a2);
    sjwCfg = 2'(sj); busIdle = 1'b0; txDominant = 1'b0; rxIn = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    while (tickN < numQ) begin
      int expTick;
      string sTag;
      expTick = ((k + 1) % T == 0) ? 1 : 0;
      sTag = (k == 0) ? "R2" : tag;
      chk((k == 0) ? "R2" : "R1", "tqTick", int'(tqTick), expTick);
      chk({"R3/", sTag}, "segment", int'(segment), expSeg);
      chk({"R4/", sTag}, "samplePulse", int'(samplePulse), expSample);
      chk({"R5/", sTag}, "bitEndPulse", int'(bitEndPulse), expEnd);
      chk({"R4/", sTag}, "sampledBit", int'(sampledBit), expBit);

      // Drive inputs for the coming edge.
      busIdle    = (tickN < idleTicks);
      txDominant = txd[0];
      if (mode == 1)      rxIn = (((tickN / halfPer) % 2) == 1) ? 1'b0 : 1'b1;
      else if (mode == 2) rxIn = (lfsr[0] | lfsr[3]);
      else                rxIn = 1'b1;

      expSample = 0;
      expEnd = 0;
      if (expTick == 1) begin
        int edgeSeen, oldS1, L;
        oldS1 = ms1;
        edgeSeen = (ms2 == 1 && ms1 == 0) ? 1 : 0;
        ms2 = ms1;
        ms1 = int'(rxIn);
        if (edgeSeen == 1 && busIdle) begin
          pos = 1; ext = 0; cut = 0; used = 1;
        end else begin
          if (edgeSeen == 1 && !busIdle && used == 0 && pos != 0) begin
            if (pos <= P + A + ext) begin
              ext = minI(pos, S); used = 1;
            end else if (txd == 0) begin
              cut = minI(P + A + ext + B - pos, S); used = 1;
            end
          end
          L = 1 + P + A + ext + B - cut;
          if (pos == P + A + ext) begin
            expSample = 1;
            expBit = oldS1;
          end
          if (pos == L - 1) begin
            expEnd = 1; pos = 0; ext = 0; cut = 0; used = 0;
          end else begin
            pos++;
          end
        end
        if (pos == 0)                expSeg = 0;
        else if (pos <= P)           expSeg = 1;
        else if (pos <= P + A + ext) expSeg = 2;
        else                         expSeg = 3;
        tickN++;
        lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
      end
      k++;
      @(negedge clk);
    end
  endtask

  initial begin
    // R3 R4 R5: plain sequencing, shortest tick period, idle-high line.
    runScn(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 60, "R3");
    // R1: divide by 4, prescaler 4, square wave.
    runScn(2, 3, 2, 3, 2, 1, 0, 1, 7, 0, 40, "R1");
    // R1: select code above range saturates at divide by 16.
    runScn(6, 1, 1, 2, 1, 0, 0, 0, 0, 0, 20, "R1");
    // R7: edge during idle forces hard synchronization.
    runScn(0, 1, 2, 3, 3, 1, 12, 1, 5, 0, 200, "R7");
    // R8: slow line, late edges stretch phase one.
    runScn(0, 1, 2, 3, 2, 3, 0, 1, 14, 0, 400, "R8");
    // R9: fast line, early edges trim phase two.
    runScn(0, 1, 2, 3, 2, 3, 0, 1, 9, 0, 400, "R9");
    // R12: same fast line while transmitting dominant.
    runScn(0, 1, 2, 3, 2, 3, 0, 1, 9, 1, 400, "R12");
    // R11 R6: glitch trains, several edges per bit, rising steps.
    runScn(0, 1, 1, 2, 2, 1, 0, 2, 0, 0, 600, "R11/R6");
    // R10: glitch trains after an idle start, edges in the sync quantum.
    runScn(1, 0, 0, 4, 3, 2, 50, 2, 0, 0, 400, "R10");
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      failCount++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule